// File: doc/BRIEF.md
# Slow Clock Calibration Counter

The block measures how long a programmed number of slow-clock periods lasts, expressed in cycles of a fast reference clock. One of three slow clocks is chosen by a source select. Each slow clock passes through its own two-flop synchroniser and rising-edge detector in the reference domain, so the selection is made on clean single-cycle edge pulses and never on a raw asynchronous clock. A single reference counter and a single slow-edge counter serve both operating modes.

In one-shot mode, a rising edge on the start bit arms a measurement. Counting begins at the first selected slow edge after that. When the programmed number of further slow edges has arrived, the count is published and a ready flag is set. In continuous mode, which is active whenever the disable input is low (its reset value), measurements follow each other with no gap: the edge that closes one measurement also opens the next, and a one-cycle valid pulse accompanies every fresh result. A reference-cycle timeout ends any measurement whose slow clock has stopped.

Software works out the period and frequency from the count. It clears the continuous mode before it starts a one-shot run, and it changes the select and the cycle count only while continuous mode is off.

Top module: `slowcal`

## Requirements
- R1: In one-shot mode (cycleOff = 1), with the selected slow clock at a steady period of P reference cycles and maxCycles = N ≥ 1, a run started by a 0-to-1 transition of startOneShot publishes calValue = N·P and sets calReady. The run uses no further input.
- R2: calReady and calTimeout are both 0 in the cycle after the reference edge that samples a start transition.
- R3: In continuous mode each completed measurement publishes calValue = N·P together with a cycValid pulse lasting exactly one cycle. Consecutive pulses are N·P cycles apart, so no slow period is lost between measurements.
- R4: Continuous mode runs whenever cycleOff = 0, including straight after reset, with no start bit needed. Entering it clears calReady. While cycleOff = 1, cycValid stays 0.
- R5: srcSel values 0, 1 and 2 select slowClk[0], slowClk[1] and slowClk[2]. The value 3 selects no source, so no edge is ever seen.
- R6: With timeoutThres = T, a one-shot run that does not complete sets calTimeout exactly T+1 cycles after the edge that sampled the start transition. The run then ends without setting calReady.
- R7: maxCycles = 0 never completes, even with a live slow clock. Such a run can only end by timeout.
- R8: calValue holds its last published value through timeouts and idle time. It changes only together with a cycValid pulse or a rising calReady.
- R9: While cycleOff = 0, startOneShot transitions are ignored: calReady stays 0 and continuous results keep arriving.
- R10: During reset calValue, calReady, calTimeout and cycValid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowClk | input | NUM_SRC (3) | Slow clock sources, asynchronous to clk |
| srcSel | input | SEL_W (2) | Source select; 3 selects none |
| maxCycles | input | SLOW_W (15) | Number of slow periods N per measurement |
| timeoutThres | input | REF_W (24) | Timeout threshold in reference cycles |
| startOneShot | input | 1 | One-shot start; acts on a 0-to-1 transition |
| cycleOff | input | 1 | 1 disables continuous mode |
| calValue | output | REF_W (24) | Last published reference count |
| calReady | output | 1 | One-shot result ready |
| calTimeout | output | 1 | Last measurement timed out |
| cycValid | output | 1 | One-cycle pulse with each continuous result |

## Verification
The assertions check on every cycle that calReady and calTimeout are never set together, and that calValue changes only alongside a cycValid pulse or a rising calReady. They also check that cycValid is a single-cycle pulse that never appears while continuous mode is off, and that calReady rises only after a cycle with continuous mode disabled. The exact counts N·P for each source, the N·P spacing of back-to-back results, the T+1 timeout latency, the N = 0 case, the dead-source select and the ignored start bit depend on the shape of the slow-clock stimulus. Only the bench scenarios can show these.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic timerInc;
    logic cntClr;
    logic cntInc;
    logic slowInc;
    logic publish;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic lastEdge;
    logic timerHit;
  } dpStat_t;

endpackage

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] slowClk,
  input  logic [SEL_W-1:0]   srcSel,
  output logic               edgeSeen
);

  logic [NUM_SRC-1:0] riseVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic meta;
    logic stable;
    logic prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        prev   <= 1'b0;
      end else begin
        meta   <= slowClk[i];
        stable <= meta;
        prev   <= stable;
      end
    end
    assign riseVec[i] = stable & ~prev;
  end

  // selection on synchronised pulses; out-of-range select sees nothing
  always_comb begin
    edgeSeen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcSel == SEL_W'(i)) edgeSeen = riseVec[i];
    end
  end

endmodule

// File: rtl/slowcal_dp.sv
module slowcal_dp
  import slowcal_pkg::*;
#(
  parameter int REF_W  = 24,
  parameter int SLOW_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SLOW_W-1:0] maxCycles,
  input  logic [REF_W-1:0]  timeoutThres,
  output dpStat_t           stat,
  output logic [REF_W-1:0]  calValue
);

  logic [REF_W-1:0]  refCnt;
  logic [SLOW_W-1:0] slowCnt;
  logic [REF_W-1:0]  timer;
  logic [REF_W-1:0]  refNext;
  logic [SLOW_W-1:0] slowNext;

  assign refNext  = refCnt + 1'b1;
  assign slowNext = slowCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      slowCnt <= '0;
    end else if (ctl.cntClr) begin
      refCnt  <= '0;
      slowCnt <= '0;
    end else begin
      if (ctl.cntInc)  refCnt  <= refNext;
      if (ctl.slowInc) slowCnt <= slowNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timer <= '0;
    else if (ctl.timerClr) timer <= '0;
    else if (ctl.timerInc) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            calValue <= '0;
    else if (ctl.publish) calValue <= refNext;
  end

  // a zero cycle count never matches, so such a run only ends by timeout
  assign stat.lastEdge = (maxCycles != '0) && (slowNext == maxCycles);
  assign stat.timerHit = (timer == timeoutThres);

endmodule

// File: rtl/slowcal_ctrl.sv
module slowcal_ctrl
  import slowcal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startOneShot,
  input  logic    cycleOff,
  input  logic    edgeSeen,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    calReady,
  output logic    calTimeout,
  output logic    cycValid
);

  calState_t st, stNext;
  logic contRun, contNext;
  logic startPrev;
  logic startRise;
  logic rdyNext, toNext, valNext;

  assign startRise = startOneShot & ~startPrev & cycleOff;

  always_comb begin
    ctl      = '0;
    stNext   = st;
    contNext = contRun;
    rdyNext  = calReady;
    toNext   = calTimeout;
    valNext  = 1'b0;
    if (startRise) begin
      stNext       = ST_ARM;
      contNext     = 1'b0;
      rdyNext      = 1'b0;
      toNext       = 1'b0;
      ctl.timerClr = 1'b1;
    end else if (st == ST_IDLE) begin
      if (!cycleOff) begin
        stNext       = ST_ARM;
        contNext     = 1'b1;
        rdyNext      = 1'b0;
        ctl.timerClr = 1'b1;
      end
    end else if (contRun && cycleOff) begin
      stNext = ST_IDLE;
    end else if (st == ST_COUNT && edgeSeen && stat.lastEdge) begin
      ctl.publish  = 1'b1;
      ctl.cntClr   = 1'b1;
      ctl.timerClr = 1'b1;
      toNext       = 1'b0;
      if (contRun) begin
        valNext = 1'b1;
      end else begin
        rdyNext = 1'b1;
        stNext  = ST_IDLE;
      end
    end else if (stat.timerHit) begin
      toNext       = 1'b1;
      ctl.timerClr = 1'b1;
      stNext       = contRun ? ST_ARM : ST_IDLE;
    end else begin
      ctl.timerInc = 1'b1;
      if (st == ST_ARM) begin
        if (edgeSeen) begin
          stNext     = ST_COUNT;
          ctl.cntClr = 1'b1;
        end
      end else begin
        ctl.cntInc  = 1'b1;
        ctl.slowInc = edgeSeen;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      contRun    <= 1'b0;
      startPrev  <= 1'b0;
      calReady   <= 1'b0;
      calTimeout <= 1'b0;
      cycValid   <= 1'b0;
    end else begin
      st         <= stNext;
      contRun    <= contNext;
      startPrev  <= startOneShot;
      calReady   <= rdyNext;
      calTimeout <= toNext;
      cycValid   <= valNext;
    end
  end

endmodule

// File: rtl/slowcal.sv
module slowcal
  import slowcal_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int REF_W   = 24,
  parameter int SLOW_W  = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] slowClk,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [SLOW_W-1:0]  maxCycles,
  input  logic [REF_W-1:0]   timeoutThres,
  input  logic               startOneShot,
  input  logic               cycleOff,
  output logic [REF_W-1:0]   calValue,
  output logic               calReady,
  output logic               calTimeout,
  output logic               cycValid
);

  logic    edgeSeen;
  dpCtl_t  ctl;
  dpStat_t stat;

  slowcal_edge_sync #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sync (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .srcSel(srcSel), .edgeSeen(edgeSeen)
  );

  slowcal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startOneShot(startOneShot), .cycleOff(cycleOff),
    .edgeSeen(edgeSeen), .stat(stat), .ctl(ctl),
    .calReady(calReady), .calTimeout(calTimeout), .cycValid(cycValid)
  );

  slowcal_dp #(.REF_W(REF_W), .SLOW_W(SLOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .maxCycles(maxCycles),
    .timeoutThres(timeoutThres), .stat(stat), .calValue(calValue)
  );

endmodule

// File: rtl/slowcal_checker.sv
module slowcal_checker #(
  parameter int REF_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleOff,
  input logic [REF_W-1:0] calValue,
  input logic             calReady,
  input logic             calTimeout,
  input logic             cycValid
);

  // R2 / R6: a run ends either ready or timed out, never both
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(calReady && calTimeout));

  // R8: result changes only with a fresh completion
  p_value_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(calValue) |-> (cycValid || $rose(calReady)));

  // R3: valid is a single-cycle pulse
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |=> !cycValid);

  // R4: no continuous result while continuous mode is off
  p_no_valid_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cycleOff) |-> !cycValid);

  // R1: ready only from a one-shot run
  p_ready_oneshot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calReady) |-> $past(cycleOff));

endmodule

bind slowcal slowcal_checker #(.REF_W(REF_W)) u_chk (.*);

// File: tb/slowcal_test.sv
module slowcal_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  slowClk = 3'b000;
  logic [1:0]  srcSel = 2'd1;
  logic [14:0] maxCycles = 15'd3;
  logic [23:0] timeoutThres = 24'd2000;
  logic        startOneShot = 1'b0;
  logic        cycleOff = 1'b0;
  logic [23:0] calValue;
  logic        calReady, calTimeout, cycValid;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slowcal uut (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .srcSel(srcSel),
    .maxCycles(maxCycles), .timeoutThres(timeoutThres),
    .startOneShot(startOneShot), .cycleOff(cycleOff),
    .calValue(calValue), .calReady(calReady), .calTimeout(calTimeout),
    .cycValid(cycValid)
  );

  // slow clock sources: periods 6, 10, 14 reference cycles
  int periods [3] = '{6, 10, 14};
  int phase [3] = '{0, 0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (phase[i] == periods[i] / 2 - 1) begin
        phase[i] <= 0;
        slowClk[i] <= ~slowClk[i];
      end else begin
        phase[i] <= phase[i] + 1;
      end
    end
  end

  function automatic int expCount(int sel, int n);
    return (sel < 3) ? n * periods[sel] : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-shot run; returns cycles after the sampling edge until a flag rose
  task automatic runOneShot(int sel, int n, int thres, output int lat, output bit gotReady,
                            output bit gotTimeout);
    srcSel = 2'(sel);
    maxCycles = 15'(n);
    timeoutThres = 24'(thres);
    startOneShot = 1'b1;
    step();
    check(!calReady && !calTimeout, "R2", {30'd0, calReady, calTimeout}, 0);
    startOneShot = 1'b0;
    lat = 1;
    gotReady = 0;
    gotTimeout = 0;
    while (lat < 3000) begin
      step();
      if (calReady || calTimeout) begin
        gotReady = calReady;
        gotTimeout = calTimeout;
        break;
      end
      lat++;
    end
  endtask

  initial begin : main
    int lat;
    bit gr, gt;
    int lastPulse;
    int pulses;
    int held;
    int cyc;
    void'($urandom(32'd20240611));

    // R10: reset state
    @(negedge clk);
    check(calValue == 0 && !calReady && !calTimeout && !cycValid, "R10",
          {calValue, 8'd0} | int'({calReady, calTimeout, cycValid}), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 / R3: continuous from reset, source 1, N = 3
    pulses = 0;
    lastPulse = -1;
    cyc = 0;
    while (pulses < 4 && cyc < 1000) begin
      step();
      cyc++;
      if (cycValid) begin
        check(calValue == 24'(expCount(1, 3)), "R3 value", int'(calValue), expCount(1, 3));
        if (lastPulse >= 0)
          check(cyc - lastPulse == expCount(1, 3), "R3 spacing", cyc - lastPulse, expCount(1, 3));
        lastPulse = cyc;
        pulses++;
      end
      if (pulses == 0 && cyc == 1) check(!calReady, "R4 ready", int'(calReady), 0);
    end
    check(pulses == 4, "R4 running from reset", pulses, 4);

    // continuous off: no pulses
    cycleOff = 1'b1;
    step();
    pulses = 0;
    for (int k = 0; k < 60; k++) begin
      step();
      if (cycValid) pulses++;
    end
    check(pulses == 0, "R4 off", pulses, 0);

    // R1 / R5: random one-shot runs on each source
    for (int k = 0; k < 10; k++) begin
      int sel = (k < 3) ? k : int'($urandom % 3);
      int n = 1 + int'($urandom % 8);
      runOneShot(sel, n, 2000, lat, gr, gt);
      check(gr && !gt, "R1 ready", int'({gr, gt}), 2);
      check(calValue == 24'(expCount(sel, n)), "R1 R5 value", int'(calValue), expCount(sel, n));
    end

    // R6 / R5 / R8: dead source select 3 times out after T+1
    held = int'(calValue);
    foreach (periods[j]) begin
      int t = (j == 0) ? 0 : ((j == 1) ? 5 : 37);
      runOneShot(3, 4, t, lat, gr, gt);
      check(gt && !gr, "R6 flag", int'({gr, gt}), 1);
      check(lat == t + 1, "R6 latency", lat, t + 1);
      check(calValue == 24'(held), "R8 hold", int'(calValue), held);
    end

    // R7: N = 0 with live source only times out
    runOneShot(0, 0, 300, lat, gr, gt);
    check(gt && !gr, "R7 flag", int'({gr, gt}), 1);
    check(lat == 301, "R7 latency", lat, 301);
    check(calValue == 24'(held), "R8 hold after R7", int'(calValue), held);

    // fresh run then ready cleared by next start (R2 inside runOneShot)
    runOneShot(2, 2, 2000, lat, gr, gt);
    check(gr && calValue == 24'(expCount(2, 2)), "R1 src2", int'(calValue), expCount(2, 2));

    // R9: start ignored while continuous on
    srcSel = 2'd0;
    maxCycles = 15'd5;
    timeoutThres = 24'd2000;
    cycleOff = 1'b0;
    step();
    pulses = 0;
    gr = 0;
    gt = 0;
    for (int k = 0; k < 200; k++) begin
      startOneShot = (k % 20) < 10;
      step();
      if (calReady) gr = 1;
      if (calTimeout) gt = 1;
      if (cycValid) begin
        pulses++;
        check(calValue == 24'(expCount(0, 5)), "R9 value", int'(calValue), expCount(0, 5));
      end
    end
    startOneShot = 1'b0;
    check(!gr && !gt, "R9 flags", int'({gr, gt}), 0);
    check(pulses >= 5, "R9 results continue", pulses, 5);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule